// File: doc/BRIEF.md
# Serial Bus Controller Register Front End

This block is the software-visible face of a two-wire serial bus master. It holds a small set of 32-bit registers on a simple read/write bus, and it sequences each operation handed to the serial engine that sits behind it. Software loads a command code, a target register number, write data and a device address, then sets the start bit. The front end raises a one-cycle launch pulse toward the engine, holds every operand stable while the engine runs, and records how the engine finished. It also launches a one-shot initialization sequence that moves every attached slave into the reduced protocol, using a mode word that software supplies.

Completion, error and rejected-write events go into a write-one-to-clear status register, and they drive an interrupt line through per-source enables and a global enable. Read results come back through the data register, with every bit above the access width forced to zero. A line-control register forces the clock and data wires to fixed levels and reads back their synchronized state. The clock register sets the divider and the data-output delay for the engine. The reset input is asynchronous and active low, and it must be released in step with the clock.

Top module: `serbus_regfront`

## Requirements
- R1: After reset every register reads zero except the clock register at offset 0x04, which reads 0x0000_010F (delay 1, divider 15). Unmapped offsets read zero, and irq, eng_go and eng_abort are low.
- R2: A write to control (0x00) with bit 7 set and bit 0 clear, made while the block is idle, raises eng_go for exactly one cycle, in the cycle after the write, with eng_op = 0. Control bit 7 then reads 1 until the engine reports completion. eng_cmd, eng_reg, eng_wdata, eng_rta and eng_hwaddr show the command (0x2C), register address (0x10), data (0x1C) and device-address (0x30, runtime 23:16, hardware 15:0) registers.
- R3: A completion (eng_done while active) with no error sets status bit 0. If the acknowledge error is set, status bits 1 and 16 are set instead. If the data-error mask is nonzero, bit 1 is set and the mask is ORed into bits 11:8. eng_done while idle changes nothing.
- R4: When a transfer completes, the data register is loaded with eng_rdata masked to 8 bits for command 0x8B, 16 bits for 0x9C and 32 bits for 0xA6. Any other command leaves the data register unchanged.
- R5: While a transfer or an initialization is active, a write to 0x10, 0x1C, 0x28, 0x2C or 0x30 leaves the register unchanged, and so does a start request. Each such write sets status bit 2 (load busy), and a rejected start produces no eng_go.
- R6: Control bit 6 written while active ends the operation at the next edge, pulses eng_abort for one cycle and sets status bit 1. Bit 6 always reads 0, and abort while idle has no effect.
- R7: Control bit 0 reads 1 for exactly one cycle after it is written. Every register then returns to its reset value, and an operation in progress is ended with one eng_abort pulse.
- R8: A write to 0x28 with bit 31 set, made while idle, stores bits 23:0 as the mode word on eng_mode and pulses eng_go with eng_op = 1. Bit 31 reads 1 until completion, and completion sets the status bits as in R3.
- R9: Writing 1 to a status bit (0, 1, 2, 8 to 11, 16) clears it and writing 0 leaves it. A bit that is set in the same cycle as it is cleared stays set.
- R10: irq is high exactly when control bit 1 is set and status bits 2:0 ANDed with enable bits 2:0 (offset 0x08) are not all zero.
- R11: Line-control bits 3, 2, 1 and 0 drive force_scl_lvl, force_scl_en, force_sda_lvl and force_sda_en. Bits 5 and 4 read line_scl and line_sda after SYNC_STAGES clock edges.
- R12: Clock register bits 7:0 drive clk_div and bits 10:8 drive sda_dly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | Write when high |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| eng_go | output | 1 | One-cycle launch pulse |
| eng_op | output | 1 | 0 transfer, 1 initialization |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_cmd | output | 8 | Command code |
| eng_reg | output | 8 | Slave register number |
| eng_wdata | output | 32 | Write data |
| eng_rta | output | 8 | Runtime address |
| eng_hwaddr | output | 16 | Hardware address |
| eng_mode | output | 24 | Initialization mode word |
| eng_done | input | 1 | Engine finished |
| eng_ack_err | input | 1 | Acknowledge error at finish |
| eng_data_err | input | 4 | Per-byte data error mask at finish |
| eng_rdata | input | 32 | Read result at finish |
| clk_div | output | 8 | Bus clock divider |
| sda_dly | output | 3 | Data output delay |
| line_scl | input | 1 | Observed clock wire |
| line_sda | input | 1 | Observed data wire |
| force_scl_en | output | 1 | Force clock wire |
| force_scl_lvl | output | 1 | Forced clock level |
| force_sda_en | output | 1 | Force data wire |
| force_sda_lvl | output | 1 | Forced data level |

## Verification
The hardest case to reach is a status bit that is set and cleared in the same cycle. The bench reaches it with a task that raises eng_done and writes a one-to-clear to the status register on the same clock edge. Two other cases need precise timing from the ports. One is a soft reset issued while a transfer is still running, where control must read with bit 0 set for one cycle before everything returns to reset. The other is a load register written during an initialization rather than during a transfer. The bench aims each of these at a fixed cycle, and a behavioural model compares every output on every clock.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CLK  = 8'h04;
  localparam logic [7:0] OFF_IEN  = 8'h08;
  localparam logic [7:0] OFF_IST  = 8'h0C;
  localparam logic [7:0] OFF_REG  = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h1C;
  localparam logic [7:0] OFF_LINE = 8'h24;
  localparam logic [7:0] OFF_MODE = 8'h28;
  localparam logic [7:0] OFF_CMD  = 8'h2C;
  localparam logic [7:0] OFF_DEV  = 8'h30;

  localparam logic [7:0] CMD_RD8  = 8'h8B;
  localparam logic [7:0] CMD_RD16 = 8'h9C;
  localparam logic [7:0] CMD_RD32 = 8'hA6;

  typedef enum logic {OP_XFER = 1'b0, OP_INIT = 1'b1} op_e;

  // status vector packing: [0] done, [1] error, [2] load busy, [6:3] data mask, [7] ack error
  localparam int ST_W = 8;

  function automatic logic [31:0] rd_keep(input logic [7:0] cmd);
    case (cmd)
      CMD_RD8:  return 32'h0000_00FF;
      CMD_RD16: return 32'h0000_FFFF;
      CMD_RD32: return 32'hFFFF_FFFF;
      default:  return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/sbf_sync.sv
module sbf_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sbf_seq.sv
module sbf_seq
  import sbf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic start_req,
  input  logic init_req,
  input  logic abort_req,
  input  logic done_in,
  output logic xfer_busy,
  output logic init_busy,
  output logic go,
  output logic op,
  output logic abort_p,
  output logic fin,
  output logic abort_ok,
  output logic reject
);
  logic active, acc_start, acc_init;
  logic xfer_busy_n, init_busy_n, go_n, op_n, abort_p_n;

  always_comb begin
    active    = xfer_busy | init_busy;
    acc_start = start_req & ~active;
    acc_init  = init_req & ~active & ~start_req;
    fin       = done_in & active;
    abort_ok  = abort_req & active & ~done_in;
    reject    = (start_req | init_req) & active;

    xfer_busy_n = xfer_busy;
    init_busy_n = init_busy;
    op_n        = op;
    go_n        = acc_start | acc_init;
    abort_p_n   = abort_ok;
    if (srst) begin
      xfer_busy_n = 1'b0;
      init_busy_n = 1'b0;
      go_n        = 1'b0;
      op_n        = OP_XFER;
      abort_p_n   = active;
    end else begin
      if (fin | abort_ok) begin
        xfer_busy_n = 1'b0;
        init_busy_n = 1'b0;
      end
      if (acc_start) begin
        xfer_busy_n = 1'b1;
        op_n        = OP_XFER;
      end
      if (acc_init) begin
        init_busy_n = 1'b1;
        op_n        = OP_INIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_busy <= 1'b0;
      init_busy <= 1'b0;
      go        <= 1'b0;
      op        <= OP_XFER;
      abort_p   <= 1'b0;
    end else begin
      xfer_busy <= xfer_busy_n;
      init_busy <= init_busy_n;
      go        <= go_n;
      op        <= op_n;
      abort_p   <= abort_p_n;
    end
  end

  a_r2_go_single: assert property (@(posedge clk) disable iff (!rst_n) go |=> !go);
  a_r2_go_has_owner: assert property (@(posedge clk) disable iff (!rst_n) go |-> (xfer_busy || init_busy));
  a_r8_one_owner: assert property (@(posedge clk) disable iff (!rst_n) !(xfer_busy && init_busy));
  a_r6_abort_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n) abort_p |-> !(xfer_busy || init_busy));
endmodule

// File: rtl/sbf_status.sv
module sbf_status
  import sbf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_bits,
  input  logic            fin,
  input  logic            fin_ack,
  input  logic [3:0]      fin_dmask,
  input  logic            abort_ok,
  input  logic            lbsy_set,
  input  logic [2:0]      ien,
  input  logic            gie,
  output logic [ST_W-1:0] st,
  output logic            irq
);
  logic            bad;
  logic [ST_W-1:0] set_v, st_n;

  always_comb begin
    bad   = fin_ack | (|fin_dmask);
    set_v = '0;
    set_v[0]   = fin & ~bad;
    set_v[1]   = (fin & bad) | abort_ok;
    set_v[2]   = lbsy_set;
    set_v[6:3] = fin ? fin_dmask : 4'd0;
    set_v[7]   = fin & fin_ack;
    if (srst) st_n = '0;
    else      st_n = (st & ~(clr_we ? clr_bits : '0)) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= st_n;
  end

  assign irq = gie & (|(st[2:0] & ien));

  a_r10_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n) irq |-> gie);
  a_r3_finish_leaves_mark: assert property (@(posedge clk) disable iff (!rst_n) (fin && !srst) |=> (st[0] || st[1]));
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n) (lbsy_set && !srst) |=> st[2]);
endmodule

// File: rtl/serbus_regfront.sv
module serbus_regfront
  import sbf_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DIV_RST     = 8'd15,
  parameter logic [2:0] DLY_RST     = 3'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        eng_go,
  output logic        eng_op,
  output logic        eng_abort,
  output logic [7:0]  eng_cmd,
  output logic [7:0]  eng_reg,
  output logic [31:0] eng_wdata,
  output logic [7:0]  eng_rta,
  output logic [15:0] eng_hwaddr,
  output logic [23:0] eng_mode,
  input  logic        eng_done,
  input  logic        eng_ack_err,
  input  logic [3:0]  eng_data_err,
  input  logic [31:0] eng_rdata,
  output logic [7:0]  clk_div,
  output logic [2:0]  sda_dly,
  input  logic        line_scl,
  input  logic        line_sda,
  output logic        force_scl_en,
  output logic        force_scl_lvl,
  output logic        force_sda_en,
  output logic        force_sda_lvl
);
  logic        srst_pend, gie;
  logic [7:0]  div_r, reg_r, cmd_r, rta_r;
  logic [2:0]  dly_r, ien_r;
  logic [31:0] data_r;
  logic [3:0]  line_r;
  logic [23:0] mode_r;
  logic [15:0] hw_r;

  logic        srst_pend_n, gie_n;
  logic [7:0]  div_n, reg_n, cmd_n, rta_n;
  logic [2:0]  dly_n, ien_n;
  logic [31:0] data_n, keep;
  logic [3:0]  line_n;
  logic [23:0] mode_n;
  logic [15:0] hw_n;

  logic wr_en, w_ctrl, w_clk, w_ien, w_ist, w_reg, w_data, w_line, w_mode, w_cmd, w_dev;
  logic start_req, abort_req, init_req, load_wr, lbsy_set, active;
  logic xfer_busy, init_busy, fin, abort_ok, reject;
  logic [ST_W-1:0] st, clr_bits;
  logic [1:0] line_s;

  always_comb begin
    wr_en  = bus_sel & bus_wr & ~srst_pend;
    w_ctrl = wr_en & (bus_addr == OFF_CTRL);
    w_clk  = wr_en & (bus_addr == OFF_CLK);
    w_ien  = wr_en & (bus_addr == OFF_IEN);
    w_ist  = wr_en & (bus_addr == OFF_IST);
    w_reg  = wr_en & (bus_addr == OFF_REG);
    w_data = wr_en & (bus_addr == OFF_DATA);
    w_line = wr_en & (bus_addr == OFF_LINE);
    w_mode = wr_en & (bus_addr == OFF_MODE);
    w_cmd  = wr_en & (bus_addr == OFF_CMD);
    w_dev  = wr_en & (bus_addr == OFF_DEV);

    active    = xfer_busy | init_busy;
    start_req = w_ctrl & bus_wdata[7] & ~bus_wdata[0];
    abort_req = w_ctrl & bus_wdata[6] & ~bus_wdata[0];
    init_req  = w_mode & bus_wdata[31];
    load_wr   = w_reg | w_data | w_mode | w_cmd | w_dev;
    lbsy_set  = (load_wr & active) | reject;
    clr_bits  = {bus_wdata[16], bus_wdata[11:8], bus_wdata[2:0]};
    keep      = rd_keep(cmd_r);
  end

  // next-state for the register file
  always_comb begin
    srst_pend_n = w_ctrl & bus_wdata[0];
    gie_n  = gie;
    div_n  = div_r;
    dly_n  = dly_r;
    ien_n  = ien_r;
    reg_n  = reg_r;
    data_n = data_r;
    line_n = line_r;
    mode_n = mode_r;
    cmd_n  = cmd_r;
    rta_n  = rta_r;
    hw_n   = hw_r;
    if (srst_pend) begin
      srst_pend_n = 1'b0;
      gie_n  = 1'b0;
      div_n  = DIV_RST;
      dly_n  = DLY_RST;
      ien_n  = '0;
      reg_n  = '0;
      data_n = '0;
      line_n = '0;
      mode_n = '0;
      cmd_n  = '0;
      rta_n  = '0;
      hw_n   = '0;
    end else begin
      if (w_ctrl && !bus_wdata[0]) gie_n = bus_wdata[1];
      if (w_clk) begin
        div_n = bus_wdata[7:0];
        dly_n = bus_wdata[10:8];
      end
      if (w_ien)  ien_n  = bus_wdata[2:0];
      if (w_line) line_n = bus_wdata[3:0];
      if (!active) begin
        if (w_reg)  reg_n  = bus_wdata[7:0];
        if (w_data) data_n = bus_wdata;
        if (w_mode) mode_n = bus_wdata[23:0];
        if (w_cmd)  cmd_n  = bus_wdata[7:0];
        if (w_dev) begin
          rta_n = bus_wdata[23:16];
          hw_n  = bus_wdata[15:0];
        end
      end
      if (fin && xfer_busy && (keep != 32'd0)) data_n = eng_rdata & keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_pend <= 1'b0;
      gie       <= 1'b0;
      div_r     <= DIV_RST;
      dly_r     <= DLY_RST;
      ien_r     <= '0;
      reg_r     <= '0;
      data_r    <= '0;
      line_r    <= '0;
      mode_r    <= '0;
      cmd_r     <= '0;
      rta_r     <= '0;
      hw_r      <= '0;
    end else begin
      srst_pend <= srst_pend_n;
      gie       <= gie_n;
      div_r     <= div_n;
      dly_r     <= dly_n;
      ien_r     <= ien_n;
      reg_r     <= reg_n;
      data_r    <= data_n;
      line_r    <= line_n;
      mode_r    <= mode_n;
      cmd_r     <= cmd_n;
      rta_r     <= rta_n;
      hw_r      <= hw_n;
    end
  end

  sbf_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst_pend),
    .start_req (start_req),
    .init_req  (init_req),
    .abort_req (abort_req),
    .done_in   (eng_done),
    .xfer_busy (xfer_busy),
    .init_busy (init_busy),
    .go        (eng_go),
    .op        (eng_op),
    .abort_p   (eng_abort),
    .fin       (fin),
    .abort_ok  (abort_ok),
    .reject    (reject)
  );

  sbf_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst_pend),
    .clr_we    (w_ist),
    .clr_bits  (clr_bits),
    .fin       (fin),
    .fin_ack   (eng_ack_err),
    .fin_dmask (eng_data_err),
    .abort_ok  (abort_ok),
    .lbsy_set  (lbsy_set),
    .ien       (ien_r),
    .gie       (gie),
    .st        (st),
    .irq       (irq)
  );

  sbf_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({line_scl, line_sda}),
    .q     (line_s)
  );

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = {24'd0, xfer_busy, 1'b0, 4'd0, gie, srst_pend};
      OFF_CLK:  bus_rdata = {21'd0, dly_r, div_r};
      OFF_IEN:  bus_rdata = {29'd0, ien_r};
      OFF_IST:  bus_rdata = {15'd0, st[7], 4'd0, st[6:3], 5'd0, st[2:0]};
      OFF_REG:  bus_rdata = {24'd0, reg_r};
      OFF_DATA: bus_rdata = data_r;
      OFF_LINE: bus_rdata = {26'd0, line_s, line_r};
      OFF_MODE: bus_rdata = {init_busy, 7'd0, mode_r};
      OFF_CMD:  bus_rdata = {24'd0, cmd_r};
      OFF_DEV:  bus_rdata = {8'd0, rta_r, hw_r};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign eng_cmd       = cmd_r;
  assign eng_reg       = reg_r;
  assign eng_wdata     = data_r;
  assign eng_rta       = rta_r;
  assign eng_hwaddr    = hw_r;
  assign eng_mode      = mode_r;
  assign clk_div       = div_r;
  assign sda_dly       = dly_r;
  assign force_scl_lvl = line_r[3];
  assign force_scl_en  = line_r[2];
  assign force_sda_lvl = line_r[1];
  assign force_sda_en  = line_r[0];

  a_r7_srst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n) srst_pend |=> !srst_pend);
  a_r5_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n) (xfer_busy && !srst_pend) |=> $stable(cmd_r));
  a_r5_dev_frozen: assert property (@(posedge clk) disable iff (!rst_n) (init_busy && !srst_pend) |=> ($stable(hw_r) && $stable(mode_r)));
endmodule

// File: tb/serbus_regfront_bench.sv
`timescale 1ns/1ps
module serbus_regfront_bench;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'd0;
  logic        eng_done = 1'b0, eng_ack_err = 1'b0;
  logic [3:0]  eng_data_err = 4'd0;
  logic [31:0] eng_rdata = 32'd0;
  logic        line_scl = 1'b0, line_sda = 1'b0;
  wire  [31:0] bus_rdata, eng_wdata;
  wire         irq, eng_go, eng_op, eng_abort;
  wire  [7:0]  eng_cmd, eng_reg, eng_rta, clk_div;
  wire  [15:0] eng_hwaddr;
  wire  [23:0] eng_mode;
  wire  [2:0]  sda_dly;
  wire         force_scl_en, force_scl_lvl, force_sda_en, force_sda_lvl;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  serbus_regfront u_serbus_regfront (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_go(eng_go), .eng_op(eng_op),
    .eng_abort(eng_abort), .eng_cmd(eng_cmd), .eng_reg(eng_reg), .eng_wdata(eng_wdata),
    .eng_rta(eng_rta), .eng_hwaddr(eng_hwaddr), .eng_mode(eng_mode), .eng_done(eng_done),
    .eng_ack_err(eng_ack_err), .eng_data_err(eng_data_err), .eng_rdata(eng_rdata),
    .clk_div(clk_div), .sda_dly(sda_dly), .line_scl(line_scl), .line_sda(line_sda),
    .force_scl_en(force_scl_en), .force_scl_lvl(force_scl_lvl),
    .force_sda_en(force_sda_en), .force_sda_lvl(force_sda_lvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_srst, m_gie, m_xb, m_ib, m_go, m_op, m_ab;
  logic [7:0]  m_div, m_reg, m_cmd, m_rta;
  logic [2:0]  m_dly, m_ien;
  logic [31:0] m_data, m_st;
  logic [3:0]  m_line;
  logic [23:0] m_mode;
  logic [15:0] m_hw;
  logic [1:0]  m_lq[$];

  task automatic m_clear();
    m_srst = 0; m_gie = 0; m_xb = 0; m_ib = 0; m_go = 0; m_op = 0; m_ab = 0;
    m_div = 8'd15; m_dly = 3'd1; m_ien = 0; m_reg = 0; m_cmd = 0; m_rta = 0;
    m_data = 0; m_st = 0; m_line = 0; m_mode = 0; m_hw = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {24'd0, m_xb, 5'd0, m_gie, m_srst};
      8'h04: return {21'd0, m_dly, m_div};
      8'h08: return {29'd0, m_ien};
      8'h0C: return m_st;
      8'h10: return {24'd0, m_reg};
      8'h1C: return m_data;
      8'h24: return {26'd0, m_lq[$], m_line};
      8'h28: return {m_ib, 7'd0, m_mode};
      8'h2C: return {24'd0, m_cmd};
      8'h30: return {8'd0, m_rta, m_hw};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string m_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R2 control readback";
      8'h04: return "R12 clock readback";
      8'h08: return "R10 enable readback";
      8'h0C: return "R9 status readback";
      8'h24: return "R11 line readback";
      8'h28: return "R8 mode readback";
      8'h10, 8'h1C, 8'h2C, 8'h30: return "R5 load register readback";
      default: return "R1 unmapped readback";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear();
      m_lq = {};
      for (int i = 0; i < SYNC; i++) m_lq.push_front(2'b00);
    end else begin
      m_lq.push_front({line_scl, line_sda});
      void'(m_lq.pop_back());
      if (m_srst) begin
        bit was;
        was = m_xb | m_ib;
        m_clear();
        m_ab = was;
      end else begin
        bit act, w, nxb, nib, ngo, nop, nab, nsrst;
        logic [31:0] setm, clrm, nd;
        act = m_xb | m_ib; w = bus_sel && bus_wr;
        nxb = m_xb; nib = m_ib; ngo = 0; nop = m_op; nab = 0; nsrst = 0;
        setm = 0; clrm = 0; nd = m_data;
        if (eng_done && act) begin
          if (eng_ack_err || eng_data_err != 0)
            setm = 32'h2 | (32'(eng_ack_err) << 16) | (32'(eng_data_err) << 8);
          else setm = 32'h1;
          if (m_xb) begin
            if (m_cmd == 8'h8B) nd = eng_rdata & 32'hFF;
            if (m_cmd == 8'h9C) nd = eng_rdata & 32'hFFFF;
            if (m_cmd == 8'hA6) nd = eng_rdata;
          end
          nxb = 0; nib = 0;
        end
        if (w) begin
          case (bus_addr)
            8'h00: if (bus_wdata[0]) nsrst = 1;
                   else begin
                     m_gie = bus_wdata[1];
                     if (bus_wdata[7]) begin
                       if (act) setm |= 4; else begin nxb = 1; ngo = 1; nop = 0; end
                     end
                     if (bus_wdata[6] && act && !eng_done) begin nxb = 0; nib = 0; nab = 1; setm |= 2; end
                   end
            8'h04: begin m_div = bus_wdata[7:0]; m_dly = bus_wdata[10:8]; end
            8'h08: m_ien = bus_wdata[2:0];
            8'h0C: clrm = bus_wdata & 32'h0001_0F07;
            8'h10: if (act) setm |= 4; else m_reg = bus_wdata[7:0];
            8'h1C: if (act) setm |= 4; else nd = bus_wdata;
            8'h24: m_line = bus_wdata[3:0];
            8'h28: if (act) setm |= 4;
                   else begin
                     m_mode = bus_wdata[23:0];
                     if (bus_wdata[31]) begin nib = 1; ngo = 1; nop = 1; end
                   end
            8'h2C: if (act) setm |= 4; else m_cmd = bus_wdata[7:0];
            8'h30: if (act) setm |= 4; else begin m_rta = bus_wdata[23:16]; m_hw = bus_wdata[15:0]; end
            default: ;
          endcase
        end
        m_st = (m_st & ~clrm) | setm;
        m_data = nd; m_xb = nxb; m_ib = nib; m_go = ngo; m_op = nop; m_ab = nab; m_srst = nsrst;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R10 irq", {31'd0, irq}, {31'd0, m_gie && ((m_st[2:0] & m_ien) != 0)});
      chk("R2 eng_go", {31'd0, eng_go}, {31'd0, m_go});
      if (m_go) chk("R8 eng_op", {31'd0, eng_op}, {31'd0, m_op});
      chk("R6 eng_abort", {31'd0, eng_abort}, {31'd0, m_ab});
      chk(m_tag(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R12 clock outputs", {21'd0, sda_dly, clk_div}, {21'd0, m_dly, m_div});
      chk("R11 force outputs", {28'd0, force_scl_lvl, force_scl_en, force_sda_lvl, force_sda_en}, {28'd0, m_line});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, e);
  endtask

  task automatic fin(input bit ack, input logic [3:0] dm, input logic [31:0] rdv);
    @(posedge clk); #1;
    eng_done = 1; eng_ack_err = ack; eng_data_err = dm; eng_rdata = rdv;
    @(posedge clk); #1;
    eng_done = 0; eng_ack_err = 0; eng_data_err = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    rd(8'h00, 32'h0, "R1 control after reset");
    rd(8'h04, 32'h0000_010F, "R1 clock after reset");
    rd(8'h0C, 32'h0, "R1 status after reset");
    rd(8'h28, 32'h0, "R1 mode after reset");
    rd(8'h3C, 32'h0, "R1 unmapped offset");
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    // R12 clock register
    wr(8'h04, 32'h0000_0523);
    chk("R12 divider", {24'd0, clk_div}, 32'h23);
    chk("R12 delay", {29'd0, sda_dly}, 32'h5);
    // R11 line control
    line_scl = 1; line_sda = 0;
    wr(8'h24, 32'h0000_000F);
    chk("R11 force bits", {28'd0, force_scl_lvl, force_scl_en, force_sda_lvl, force_sda_en}, 32'hF);
    rd(8'h24, 32'h0000_002F, "R11 line state readback");
    // R2 transfer launch
    wr(8'h10, 32'h0000_005A);
    wr(8'h30, 32'h002D_03A3);
    wr(8'h2C, 32'h0000_008B);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0007);
    wr(8'h00, 32'h0000_0002);
    wr(8'h00, 32'h0000_0082);
    @(negedge clk);
    chk("R2 eng_go after start", {31'd0, eng_go}, 32'd1);
    chk("R2 operand cmd/reg", {16'd0, eng_cmd, eng_reg}, 32'h0000_8B5A);
    chk("R2 operand address", {8'd0, eng_rta, eng_hwaddr}, 32'h002D_03A3);
    rd(8'h00, 32'h0000_0082, "R2 busy bit");
    // R5 load while busy
    wr(8'h2C, 32'h0000_004E);
    rd(8'h2C, 32'h0000_008B, "R5 command held");
    rd(8'h0C, 32'h0000_0004, "R5 load busy flag");
    fin(0, 4'd0, 32'hDEAD_BEEF);
    rd(8'h1C, 32'h0000_00EF, "R4 8-bit read");
    rd(8'h0C, 32'h0000_0005, "R3 clean finish");
    rd(8'h00, 32'h0000_0002, "R2 busy cleared");
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    // R9 clear
    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, 32'h0000_0004, "R9 clear one bit");
    wr(8'h0C, 32'h0000_0004);
    rd(8'h0C, 32'h0000_0000, "R9 clear second bit");
    chk("R10 irq dropped", {31'd0, irq}, 32'd0);
    // R4 16-bit
    wr(8'h2C, 32'h0000_009C);
    wr(8'h00, 32'h0000_0082);
    fin(0, 4'd0, 32'h1234_BEEF);
    rd(8'h1C, 32'h0000_BEEF, "R4 16-bit read");
    // R9 set in the same cycle as clear
    wr(8'h00, 32'h0000_0082);
    @(posedge clk); #1;
    eng_done = 1; eng_rdata = 32'hAAAA_5555;
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h1;
    @(posedge clk); #1;
    eng_done = 0; bus_sel = 0; bus_wr = 0;
    rd(8'h0C, 32'h0000_0001, "R9 set wins over clear");
    rd(8'h1C, 32'h0000_5555, "R4 16-bit second read");
    // R4 write command leaves data
    wr(8'h0C, 32'h0001_0F07);
    wr(8'h2C, 32'h0000_004E);
    wr(8'h1C, 32'h1122_3344);
    wr(8'h00, 32'h0000_0082);
    chk("R2 write data on engine", eng_wdata, 32'h1122_3344);
    fin(0, 4'd0, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h1122_3344, "R4 write command keeps data");
    wr(8'h2C, 32'h0000_00A6);
    wr(8'h00, 32'h0000_0082);
    fin(0, 4'd0, 32'hCAFE_F00D);
    rd(8'h1C, 32'hCAFE_F00D, "R4 32-bit read");
    // R3 errors
    wr(8'h0C, 32'h0001_0F07);
    wr(8'h00, 32'h0000_0082);
    fin(1, 4'hA, 32'h0);
    rd(8'h0C, 32'h0001_0A02, "R3 error flags");
    fin(0, 4'h0, 32'h0);
    rd(8'h0C, 32'h0001_0A02, "R3 done while idle ignored");
    // R6 abort
    wr(8'h0C, 32'h0001_0F07);
    wr(8'h00, 32'h0000_0082);
    wr(8'h00, 32'h0000_0042);
    @(negedge clk);
    chk("R6 abort pulse", {31'd0, eng_abort}, 32'd1);
    rd(8'h00, 32'h0000_0002, "R6 start cleared");
    rd(8'h0C, 32'h0000_0002, "R6 error set");
    wr(8'h0C, 32'h0000_0002);
    wr(8'h00, 32'h0000_0042);
    rd(8'h0C, 32'h0000_0000, "R6 idle abort ignored");
    // R8 device mode
    wr(8'h28, 32'h807C_3E00);
    @(negedge clk);
    chk("R8 launch", {30'd0, eng_go, eng_op}, 32'd3);
    chk("R8 mode word", {8'd0, eng_mode}, 32'h007C_3E00);
    rd(8'h28, 32'h807C_3E00, "R8 start bit held");
    wr(8'h30, 32'h0011_2222);
    rd(8'h30, 32'h002D_03A3, "R5 address held during init");
    fin(0, 4'd0, 32'h0);
    rd(8'h28, 32'h007C_3E00, "R8 start bit cleared");
    rd(8'h0C, 32'h0000_0005, "R8 finish status");
    // R10 global enable
    wr(8'h00, 32'h0000_0000);
    chk("R10 irq gated off", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h0000_0002);
    chk("R10 irq gated on", {31'd0, irq}, 32'd1);
    // R7 soft reset during transfer
    wr(8'h00, 32'h0000_0082);
    wr(8'h00, 32'h0000_0001);
    @(negedge clk);
    chk("R7 reset bit visible", bus_rdata, 32'h0000_0083);
    @(negedge clk);
    chk("R7 abort on reset", {31'd0, eng_abort}, 32'd1);
    chk("R7 control cleared", bus_rdata, 32'h0);
    rd(8'h04, 32'h0000_010F, "R7 clock restored");
    rd(8'h2C, 32'h0, "R7 command cleared");
    chk("R7 irq low", {31'd0, irq}, 32'd0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule